// File: doc/BRIEF.md
# Door Access Controller with Building-Filtered User Cache

This block is the decision core of a door card reader. It owns a small on-chip cache of authorised users and talks to a larger external user database through a plain synchronous RAM port. A request starts with a one-cycle `startReq` carrying an operation code, a pair of credentials, an optional target user and a building code. The controller then runs to completion, holding `busy` high, and ends with exactly one single-cycle outcome pulse.

An initialisation request records the credentials as the administrator's and the code as the reader's building. It empties the cache and can wipe the external database. It then scans every external record and copies into the cache those whose ID is non-zero and whose building code equals the reader's, until the cache runs out of room. A normal entry request searches only the cache. The administrator is granted entry directly, and can also add or delete users in either memory. All address generation uses one shared counter that steps up or down by 1, 3 or 6 words. An external record is three words (ID, PIN, building code at offsets 0, 1, 2 of base 3k). A cache record is two words (ID, PIN). An ID of zero marks an empty slot.

Top module: `access_ctrl`

## Requirements
- R1: Operation code 0 (init) stores credId/credPin as the administrator, stores bldCode as the reader's building, empties the cache and, when clearExt is 1, writes zero to every external word before scanning. It ends with donePulse.
- R2: During the scan, an external record is cached only if its ID is non-zero and its building code equals the reader's. The scan stops once the cache holds INT_RECS users.
- R3: Operation code 1 (enter) with non-administrator credentials grants (grantPulse) only when a cached record holds both the non-zero ID and its PIN. Otherwise it pulses denyPulse.
- R4: An enter request whose credentials match the stored administrator is granted without a search. An add or remove request with any other credentials ends in denyPulse and changes neither memory.
- R5: Operation code 2 (add) with useExt=0 writes userId/userPin into the lowest-addressed empty cache slot and pulses donePulse. When no slot is empty, it pulses fullPulse instead.
- R6: Operation code 3 (remove) with useExt=0 writes zero over the cached record whose ID equals userId, so that later entry with it is denied. It ends with donePulse whether or not the user was found.
- R7: Add with useExt=1 finds the first external record whose ID word is zero. It writes userId, userPin and the reader's building code to its offsets 0, 1 and 2, then pulses donePulse. When no such record exists, it pulses fullPulse.
- R8: Remove with useExt=1 writes zero to the ID word of the first external record whose ID equals userId, and leaves its other words unchanged. It ends with donePulse.
- R9: extRdata is taken to be the word at the address presented one cycle earlier. extWe is raised only while busy and only at addresses below 3*EXT_RECS.
- R10: Every request ends with exactly one of grantPulse, denyPulse, fullPulse or donePulse, each lasting one cycle, in the same cycle that busy falls. After reset, busy and all pulses are low and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Starts a request; ignored while busy |
| opSel | input | 2 | 0 init, 1 enter, 2 add, 3 remove |
| useExt | input | 1 | Add/remove targets the external database when 1 |
| clearExt | input | 1 | Init wipes the external database first when 1 |
| credId | input | W | Credential ID (administrator ID at init) |
| credPin | input | W | Credential PIN |
| userId | input | W | Target user ID for add/remove |
| userPin | input | W | Target user PIN for add |
| bldCode | input | W | Building code taken at init |
| busy | output | 1 | High while a request runs |
| grantPulse | output | 1 | Entry granted |
| denyPulse | output | 1 | Entry or administrator action refused |
| fullPulse | output | 1 | Add found no empty record |
| donePulse | output | 1 | Init, add or remove completed |
| extAddr | output | AW | External word address |
| extWe | output | 1 | External write enable |
| extWdata | output | W | External write data |
| extRdata | input | W | External read data, one cycle after address |

## Verification
On every cycle, the assertions enforce that at most one outcome pulse is high. They also require that an outcome coincides with busy falling, and that busy never falls without one. External writes are checked to occur only while busy and only inside the database range. Whether the right users were cached, whether a search reached the right outcome, and which words an add or remove touched depend on memory contents. Only the bench's scenarios can show these, through their grant, deny and full outcomes and the external words they read back.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    STEP_HOLD, STEP_UP1, STEP_UP3, STEP_UP6, STEP_DN1, STEP_DN3, STEP_DN6, STEP_ZERO
  } step_e;

  typedef enum logic [1:0] {OP_INIT, OP_ENTER, OP_ADD, OP_REMOVE} op_e;
  typedef enum logic [1:0] {WSRC_ZERO, WSRC_ID, WSRC_PIN, WSRC_CODE} wsrc_e;
  typedef enum logic [1:0] {KEY_ENTER, KEY_EMPTY, KEY_TARGET} key_e;

  typedef enum logic [3:0] {
    S_IDLE, S_AUTH, S_CLR, S_SREQ, S_SID, S_SPIN, S_SBC,
    S_ICHK, S_EREQ, S_ECHK, S_WID, S_WPIN, S_WBC
  } st_e;

  typedef struct packed {
    step_e step;
    key_e  keySel;
    wsrc_e extSrc;
    logic  extWe;
    logic  intWe;
    logic  intZero;
    logic  intClr;
    logic  cfgLoad;
    logic  reqLoad;
    logic  tmpIdLd;
    logic  tmpPinLd;
    logic  fillWe;
  } ctl_t;

  typedef struct packed {
    logic adminOk;
    logic intHit;
    logic intEnd;
    logic extHit;
    logic extLastRec;
    logic extLastWord;
    logic scanKeep;
    logic fillFull;
  } sts_t;
endpackage

// File: rtl/access_ctrl_dp.sv
module access_ctrl_dp
  import acc_pkg::*;
#(
  parameter int W        = 6,
  parameter int INT_RECS = 8,
  parameter int EXT_RECS = 16,
  parameter int AW       = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctl_t         ctl,
  input  logic [W-1:0] credId,
  input  logic [W-1:0] credPin,
  input  logic [W-1:0] userId,
  input  logic [W-1:0] userPin,
  input  logic [W-1:0] bldCode,
  input  logic [W-1:0] extRdata,
  output logic [AW-1:0] extAddr,
  output logic [W-1:0] extWdata,
  output sts_t         sts
);
  localparam int INT_WORDS = 2 * INT_RECS;
  localparam int EXT_WORDS = 3 * EXT_RECS;
  localparam int IAW       = $clog2(INT_WORDS);
  localparam int FW        = $clog2(INT_RECS + 1);

  logic [AW-1:0] cnt;
  logic [W-1:0]  rId, rPin, tId, tPin, rCode;
  logic [W-1:0]  adminId, adminPin, code, tmpId, tmpPin;
  logic          adminValid;
  logic [FW-1:0] fillIdx;
  logic [W-1:0]  intMem [INT_WORDS];
  logic [IAW-1:0] intAddr, intNext, fillBase;
  logic          keyMatch;

  assign intAddr  = cnt[IAW-1:0];
  assign intNext  = intAddr + IAW'(1);
  assign fillBase = IAW'(2 * fillIdx);
  assign extAddr  = cnt;

  // shared address counter
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else begin
      case (ctl.step)
        STEP_UP1: cnt <= cnt + AW'(1);
        STEP_UP3: cnt <= cnt + AW'(3);
        STEP_UP6: cnt <= cnt + AW'(6);
        STEP_DN1: cnt <= cnt - AW'(1);
        STEP_DN3: cnt <= cnt - AW'(3);
        STEP_DN6: cnt <= cnt - AW'(6);
        STEP_ZERO: cnt <= '0;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {rId, rPin, tId, tPin, rCode} <= '0;
      {adminId, adminPin, code, tmpId, tmpPin} <= '0;
      adminValid <= 1'b0;
    end else begin
      if (ctl.reqLoad) begin
        rId <= credId; rPin <= credPin; tId <= userId; tPin <= userPin; rCode <= bldCode;
      end
      if (ctl.cfgLoad) begin
        adminId <= rId; adminPin <= rPin; code <= rCode; adminValid <= 1'b1;
      end
      if (ctl.tmpIdLd)  tmpId  <= extRdata;
      if (ctl.tmpPinLd) tmpPin <= extRdata;
    end
  end

  // cache storage and fill pointer
  always_ff @(posedge clk) begin
    if (!rstN || ctl.intClr) begin
      for (int i = 0; i < INT_WORDS; i++) intMem[i] <= '0;
      fillIdx <= '0;
    end else if (ctl.fillWe) begin
      intMem[fillBase]          <= tmpId;
      intMem[fillBase + IAW'(1)] <= tmpPin;
      fillIdx <= fillIdx + FW'(1);
    end else if (ctl.intWe) begin
      intMem[intAddr] <= ctl.intZero ? '0 : tId;
      intMem[intNext] <= ctl.intZero ? '0 : tPin;
    end
  end

  always_comb begin
    case (ctl.keySel)
      KEY_ENTER: keyMatch = (rId != '0) && (intMem[intAddr] == rId) && (intMem[intNext] == rPin);
      KEY_EMPTY: keyMatch = (intMem[intAddr] == '0);
      default:   keyMatch = (tId != '0) && (intMem[intAddr] == tId);
    endcase
  end

  always_comb begin
    case (ctl.extSrc)
      WSRC_ID:   extWdata = tId;
      WSRC_PIN:  extWdata = tPin;
      WSRC_CODE: extWdata = code;
      default:   extWdata = '0;
    endcase
  end

  assign sts.adminOk     = adminValid && (rId == adminId) && (rPin == adminPin);
  assign sts.intHit      = !intAddr[0] && keyMatch;
  assign sts.intEnd      = (cnt == AW'(INT_WORDS - 1));
  assign sts.extHit      = (ctl.keySel == KEY_EMPTY) ? (extRdata == '0)
                                                     : ((tId != '0) && (extRdata == tId));
  assign sts.extLastRec  = (cnt == AW'(EXT_WORDS));
  assign sts.extLastWord = (cnt == AW'(EXT_WORDS - 1));
  assign sts.scanKeep    = (tmpId != '0) && (extRdata == code);
  assign sts.fillFull    = (fillIdx == FW'(INT_RECS));
endmodule

// File: rtl/access_ctrl_ctl.sv
module access_ctrl_ctl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] opSel,
  input  logic       useExt,
  input  logic       clearExt,
  input  sts_t       sts,
  output ctl_t       ctl,
  output logic       busy,
  output logic       grantPulse,
  output logic       denyPulse,
  output logic       fullPulse,
  output logic       donePulse
);
  st_e  st, nxt;
  op_e  opQ;
  logic extQ, clrQ;
  logic pg, pd, pf, pn;

  always_comb begin
    ctl = '0;
    ctl.keySel = (opQ == OP_ENTER) ? KEY_ENTER : (opQ == OP_ADD) ? KEY_EMPTY : KEY_TARGET;
    nxt = st;
    {pg, pd, pf, pn} = '0;
    case (st)
      S_IDLE: if (startReq) begin ctl.reqLoad = 1'b1; ctl.step = STEP_ZERO; nxt = S_AUTH; end
      S_AUTH: begin
        if (opQ == OP_INIT) begin
          ctl.cfgLoad = 1'b1; ctl.intClr = 1'b1; nxt = clrQ ? S_CLR : S_SREQ;
        end else if (opQ == OP_ENTER) begin
          if (sts.adminOk) begin pg = 1'b1; nxt = S_IDLE; end
          else nxt = S_ICHK;
        end else if (!sts.adminOk) begin
          pd = 1'b1; nxt = S_IDLE;
        end else nxt = extQ ? S_EREQ : S_ICHK;
      end
      S_CLR: begin
        ctl.extWe = 1'b1; ctl.extSrc = WSRC_ZERO;
        if (sts.extLastWord) begin ctl.step = STEP_ZERO; nxt = S_SREQ; end
        else ctl.step = STEP_UP1;
      end
      S_SREQ: begin ctl.step = STEP_UP1; nxt = S_SID; end
      S_SID: begin
        if (sts.fillFull) begin pn = 1'b1; nxt = S_IDLE; end
        else begin ctl.tmpIdLd = 1'b1; ctl.step = STEP_UP1; nxt = S_SPIN; end
      end
      S_SPIN: begin ctl.tmpPinLd = 1'b1; ctl.step = STEP_UP1; nxt = S_SBC; end
      S_SBC: begin
        ctl.step = STEP_UP1; ctl.fillWe = sts.scanKeep;
        if (sts.extLastRec) begin pn = 1'b1; nxt = S_IDLE; end
        else nxt = S_SID;
      end
      S_ICHK: begin
        if (sts.intHit) begin
          nxt = S_IDLE;
          if (opQ == OP_ENTER) pg = 1'b1;
          else begin ctl.intWe = 1'b1; ctl.intZero = (opQ == OP_REMOVE); pn = 1'b1; end
        end else if (sts.intEnd) begin
          nxt = S_IDLE;
          if (opQ == OP_ENTER) pd = 1'b1;
          else if (opQ == OP_ADD) pf = 1'b1;
          else pn = 1'b1;
        end else ctl.step = STEP_UP1;
      end
      S_EREQ: begin ctl.step = STEP_UP3; nxt = S_ECHK; end
      S_ECHK: begin
        if (sts.extHit) begin ctl.step = STEP_DN3; nxt = S_WID; end
        else if (sts.extLastRec) begin
          nxt = S_IDLE;
          if (opQ == OP_ADD) pf = 1'b1; else pn = 1'b1;
        end else ctl.step = STEP_UP3;
      end
      S_WID: begin
        ctl.extWe = 1'b1; ctl.step = STEP_UP1;
        if (opQ == OP_ADD) begin ctl.extSrc = WSRC_ID; nxt = S_WPIN; end
        else begin ctl.extSrc = WSRC_ZERO; pn = 1'b1; nxt = S_IDLE; end
      end
      S_WPIN: begin ctl.extWe = 1'b1; ctl.extSrc = WSRC_PIN; ctl.step = STEP_UP1; nxt = S_WBC; end
      S_WBC: begin ctl.extWe = 1'b1; ctl.extSrc = WSRC_CODE; pn = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_IDLE; opQ <= OP_INIT; extQ <= 1'b0; clrQ <= 1'b0;
      {grantPulse, denyPulse, fullPulse, donePulse} <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && startReq) begin
        opQ <= op_e'(opSel); extQ <= useExt; clrQ <= clearExt;
      end
      {grantPulse, denyPulse, fullPulse, donePulse} <= {pg, pd, pf, pn};
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
  import acc_pkg::*;
#(
  parameter int W        = 6,
  parameter int INT_RECS = 8,
  parameter int EXT_RECS = 16,
  localparam int AW      = $clog2(3 * EXT_RECS + 7)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [1:0]    opSel,
  input  logic          useExt,
  input  logic          clearExt,
  input  logic [W-1:0]  credId,
  input  logic [W-1:0]  credPin,
  input  logic [W-1:0]  userId,
  input  logic [W-1:0]  userPin,
  input  logic [W-1:0]  bldCode,
  output logic          busy,
  output logic          grantPulse,
  output logic          denyPulse,
  output logic          fullPulse,
  output logic          donePulse,
  output logic [AW-1:0] extAddr,
  output logic          extWe,
  output logic [W-1:0]  extWdata,
  input  logic [W-1:0]  extRdata
);
  ctl_t ctl;
  sts_t sts;

  access_ctrl_ctl u_ctl (
    .clk, .rstN, .startReq, .opSel, .useExt, .clearExt, .sts, .ctl,
    .busy, .grantPulse, .denyPulse, .fullPulse, .donePulse
  );

  access_ctrl_dp #(.W(W), .INT_RECS(INT_RECS), .EXT_RECS(EXT_RECS), .AW(AW)) u_dp (
    .clk, .rstN, .ctl, .credId, .credPin, .userId, .userPin, .bldCode,
    .extRdata, .extAddr, .extWdata, .sts
  );

  assign extWe = ctl.extWe;
endmodule

// File: rtl/access_ctrl_chk.sv
module access_ctrl_chk #(
  parameter int EXT_RECS = 16,
  localparam int AW      = $clog2(3 * EXT_RECS + 7)
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          grantPulse,
  input logic          denyPulse,
  input logic          fullPulse,
  input logic          donePulse,
  input logic          extWe,
  input logic [AW-1:0] extAddr
);
  logic anyEnd;
  assign anyEnd = grantPulse | denyPulse | fullPulse | donePulse;

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantPulse, denyPulse, fullPulse, donePulse}));

  p_outcome_at_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyEnd |-> ($fell(busy)));

  p_end_has_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> anyEnd);

  p_write_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    extWe |-> busy);

  p_write_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    extWe |-> (int'(extAddr) < 3 * EXT_RECS));
endmodule

bind access_ctrl access_ctrl_chk #(.EXT_RECS(EXT_RECS)) u_chk (
  .clk, .rstN, .busy, .grantPulse, .denyPulse, .fullPulse, .donePulse, .extWe, .extAddr
);

// File: tb/access_ctrl_bench.sv
`timescale 1ns/1ps
module access_ctrl_bench;
  localparam int W = 6, IR = 4, ER = 8;
  localparam int EW = 3 * ER;
  localparam int AW = $clog2(EW + 7);
  localparam int OK_DONE = 0, OK_GRANT = 1, OK_DENY = 2, OK_FULL = 3;

  typedef struct packed {
    logic [3:0]   rq;
    logic [1:0]   op;
    logic         ext;
    logic [W-1:0] cid, cpin, uid, upin, bc;
    logic [1:0]   exp;
  } vec_t;

  // op: 0 init, 1 enter, 2 add, 3 remove
  localparam vec_t VECS [19] = '{
    '{4'd1,  2'd0, 1'b0, 6'd60, 6'd61, 6'd0,  6'd0,  6'd3, 2'd0}, // R1 init, code 3
    '{4'd3,  2'd1, 1'b0, 6'd5,  6'd10, 6'd0,  6'd0,  6'd0, 2'd1}, // R3 cached user
    '{4'd2,  2'd1, 1'b0, 6'd7,  6'd11, 6'd0,  6'd0,  6'd0, 2'd2}, // R2 other building
    '{4'd3,  2'd1, 1'b0, 6'd5,  6'd11, 6'd0,  6'd0,  6'd0, 2'd2}, // R3 wrong pin
    '{4'd3,  2'd1, 1'b0, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0, 2'd2}, // R3 zero id
    '{4'd4,  2'd1, 1'b0, 6'd60, 6'd61, 6'd0,  6'd0,  6'd0, 2'd1}, // R4 admin entry
    '{4'd4,  2'd2, 1'b0, 6'd1,  6'd2,  6'd40, 6'd41, 6'd0, 2'd2}, // R4 bad creds
    '{4'd4,  2'd1, 1'b0, 6'd40, 6'd41, 6'd0,  6'd0,  6'd0, 2'd2}, // R4 nothing added
    '{4'd5,  2'd2, 1'b0, 6'd60, 6'd61, 6'd20, 6'd21, 6'd0, 2'd0}, // R5 add
    '{4'd5,  2'd1, 1'b0, 6'd20, 6'd21, 6'd0,  6'd0,  6'd0, 2'd1}, // R5 added works
    '{4'd6,  2'd3, 1'b0, 6'd60, 6'd61, 6'd5,  6'd0,  6'd0, 2'd0}, // R6 remove
    '{4'd6,  2'd1, 1'b0, 6'd5,  6'd10, 6'd0,  6'd0,  6'd0, 2'd2}, // R6 removed denied
    '{4'd5,  2'd2, 1'b0, 6'd60, 6'd61, 6'd22, 6'd23, 6'd0, 2'd0}, // R5 reuse slot
    '{4'd5,  2'd2, 1'b0, 6'd60, 6'd61, 6'd24, 6'd25, 6'd0, 2'd0}, // R5 last slot
    '{4'd5,  2'd2, 1'b0, 6'd60, 6'd61, 6'd26, 6'd27, 6'd0, 2'd3}, // R5 cache full
    '{4'd5,  2'd1, 1'b0, 6'd24, 6'd25, 6'd0,  6'd0,  6'd0, 2'd1}, // R5 last slot works
    '{4'd7,  2'd2, 1'b1, 6'd60, 6'd61, 6'd30, 6'd31, 6'd0, 2'd0}, // R7 ext add
    '{4'd8,  2'd3, 1'b1, 6'd60, 6'd61, 6'd9,  6'd0,  6'd0, 2'd0}, // R8 ext remove
    '{4'd6,  2'd3, 1'b0, 6'd60, 6'd61, 6'd50, 6'd0,  6'd0, 2'd0}  // R6 absent user
  };

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, useExt = 1'b0, clearExt = 1'b0;
  logic [1:0] opSel = '0;
  logic [W-1:0] credId = '0, credPin = '0, userId = '0, userPin = '0, bldCode = '0;
  logic busy, grantPulse, denyPulse, fullPulse, donePulse, extWe;
  logic [AW-1:0] extAddr;
  logic [W-1:0] extWdata, extRdata;

  logic [W-1:0] extMem [1 << AW];
  logic preWe = 1'b0;
  logic [AW-1:0] preA = '0;
  logic [W-1:0] preD = '0;
  int nChk = 0, nFail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  access_ctrl #(.W(W), .INT_RECS(IR), .EXT_RECS(ER)) u_access_ctrl (.*);

  always @(posedge clk) begin
    if (extWe) extMem[extAddr] <= extWdata;
    else if (preWe) extMem[preA] <= preD;
    extRdata <= extMem[extAddr];
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      finishRun();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preWrite(input int a, input int d);
    @(negedge clk); preWe = 1'b1; preA = AW'(a); preD = W'(d);
    @(negedge clk); preWe = 1'b0;
  endtask

  task automatic runOp(input logic [1:0] op, input logic ext, input logic clr,
                       input logic [W-1:0] cid, cpin, uid, upin, bc, output int res);
    @(negedge clk);
    opSel = op; useExt = ext; clearExt = clr; credId = cid; credPin = cpin;
    userId = uid; userPin = upin; bldCode = bc; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    res = 4;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (grantPulse) begin res = OK_GRANT; break; end
      if (denyPulse)  begin res = OK_DENY;  break; end
      if (fullPulse)  begin res = OK_FULL;  break; end
      if (donePulse)  begin res = OK_DONE;  break; end
    end
  endtask

  initial begin
    int res;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 pulses", int'({grantPulse, denyPulse, fullPulse, donePulse}), 0);
    chk("R9 no write at reset", int'(extWe), 0);
    rstN = 1'b1;
    // R10 fresh cache: non-admin entry denied before init
    runOp(2'd1, 1'b0, 1'b0, 6'd5, 6'd10, 6'd0, 6'd0, 6'd0, res);
    chk("R10 empty after reset", res, OK_DENY);

    for (int a = 0; a < EW; a++) preWrite(a, 0);
    // records: id, pin, code at 3k, 3k+1, 3k+2
    preWrite(0, 5); preWrite(1, 10); preWrite(2, 3);
    preWrite(3, 7); preWrite(4, 11); preWrite(5, 4);
    preWrite(6, 0); preWrite(7, 9);  preWrite(8, 3);
    preWrite(9, 9); preWrite(10, 12); preWrite(11, 3);

    for (int v = 0; v < 19; v++) begin
      runOp(VECS[v].op, VECS[v].ext, 1'b0, VECS[v].cid, VECS[v].cpin,
            VECS[v].uid, VECS[v].upin, VECS[v].bc, res);
      chk($sformatf("R%0d vec%0d", VECS[v].rq, v), res, int'(VECS[v].exp));
    end

    // R7 external add landed in record 2 (words 6..8) with reader code
    chk("R7 ext id",   int'(extMem[6]), 30);
    chk("R7 ext pin",  int'(extMem[7]), 31);
    chk("R7 ext code", int'(extMem[8]), 3);
    // R8 external remove zeroed only the id word of record 3
    chk("R8 ext id cleared", int'(extMem[9]), 0);
    chk("R8 ext pin kept",   int'(extMem[10]), 12);

    // R1 init with wipe: every external word zero, cache emptied
    runOp(2'd0, 1'b0, 1'b1, 6'd60, 6'd61, 6'd0, 6'd0, 6'd3, res);
    chk("R1 init wipe done", res, OK_DONE);
    begin
      int nz = 0;
      for (int a = 0; a < EW; a++) if (extMem[a] != '0) nz++;
      chk("R1 ext words nonzero", nz, 0);
    end
    runOp(2'd1, 1'b0, 1'b0, 6'd20, 6'd21, 6'd0, 6'd0, 6'd0, res);
    chk("R1 cache emptied", res, OK_DENY);

    // R2 scan stops when the cache is full: six matching records, four slots
    for (int k = 0; k < 6; k++) begin
      preWrite(3 * k, 11 + k); preWrite(3 * k + 1, 40 + k); preWrite(3 * k + 2, 3);
    end
    runOp(2'd0, 1'b0, 1'b0, 6'd60, 6'd61, 6'd0, 6'd0, 6'd3, res);
    chk("R2 init done", res, OK_DONE);
    runOp(2'd1, 1'b0, 1'b0, 6'd14, 6'd43, 6'd0, 6'd0, 6'd0, res);
    chk("R2 fourth cached", res, OK_GRANT);
    runOp(2'd1, 1'b0, 1'b0, 6'd15, 6'd44, 6'd0, 6'd0, 6'd0, res);
    chk("R2 fifth not cached", res, OK_DENY);

    finishRun();
  end
endmodule